// File: doc/BRIEF.md
# Multiplier Operand Register Shift Chain

This block is the operand-capture front end for a row of signed multipliers. Each multiplier stage has one register on its A operand and one on its B operand. Each register loads either from its own parallel data port or, in shift mode, from the same-operand register of the stage before it. With shift mode on, the A registers form one delay line and the B registers form another. Stage 0 takes its shift input from an external port. Every stage presents its registered A and B values on shift-out ports, so the last stage can feed a further instance.

A pool of four clock enables and four asynchronous clears is shared by the whole block. Every operand register chooses its own enable and its own clear from that pool, so A and B of one stage can be frozen or cleared on their own. A register can also be bypassed, which passes its selected input straight through. Each stage multiplies its two operands as signed numbers, at full width or in a 9-bit mode.

The typical use is a FIR filter. The A line carries samples and the B line carries coefficients, and the coefficients are loaded either serially through the chain or in parallel through the data ports.

Top module: `opreg_shift_chain`

## Requirements
- R1: With shift mode off for a register, a rising clock edge while its selected enable (`*_ena_sel_i` field = index into `ena_i`) is high loads that stage's slice of `a_data_i`/`b_data_i`.
- R2: With shift mode on, a register loads the shift-out of the same operand of stage i-1. Stage 0 loads `a_sin_i`/`b_sin_i`. A line of N stages therefore delays a sample by one edge per stage.
- R3: A high level on the selected clear (`*_clr_sel_i` field = index into `aclr_i`) forces the register to zero at once, with no clock edge. Clear wins over a concurrent enable. Clears that are not selected have no effect.
- R4: While the selected enable is low the register keeps its value. Enables that are not selected have no effect.
- R5: A bypassed register (`*_bypass_i` bit = 1) drives its selected input, parallel or shift, to its shift-out and multiplier with no clock delay.
- R6: With `wide_i` bit = 1, stage i outputs the 36-bit signed product of its two 18-bit signed operands on `prod_o[36*i +: 36]`.
- R7: With `wide_i` bit = 0, only operand bits [8:0] are used, as signed values. The 18-bit product is sign-extended to 36 bits, while the full register value still travels down the chain.
- R8: Putting a stage into parallel mode ends the chain above it. That stage takes its data port, and the stages after it shift from that stage.
- R9: With A shifting samples and B holding coefficients c0..c3 (coefficient i in stage i), the sum of the four products equals the FIR output sum(c_i * x[n-i]). This holds for coefficients loaded serially and for coefficients loaded in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all operand registers |
| ena_i | input | 4 | Shared pool of clock enables |
| aclr_i | input | 4 | Shared pool of asynchronous clears, active high |
| wide_i | input | STAGES | Per stage: 1 = 18-bit operands, 0 = 9-bit operands |
| a_bypass_i | input | STAGES | Per stage: bypass the A register |
| a_shift_i | input | STAGES | Per stage: A loads from the chain (1) or the data port (0) |
| a_ena_sel_i | input | 2*STAGES | Per stage: enable pool index for A |
| a_clr_sel_i | input | 2*STAGES | Per stage: clear pool index for A |
| b_bypass_i | input | STAGES | Per stage: bypass the B register |
| b_shift_i | input | STAGES | Per stage: B loads from the chain (1) or the data port (0) |
| b_ena_sel_i | input | 2*STAGES | Per stage: enable pool index for B |
| b_clr_sel_i | input | 2*STAGES | Per stage: clear pool index for B |
| a_data_i | input | STAGES*W | Parallel A data, one W-bit slice per stage |
| b_data_i | input | STAGES*W | Parallel B data, one W-bit slice per stage |
| a_sin_i | input | W | A shift-in for stage 0 |
| b_sin_i | input | W | B shift-in for stage 0 |
| a_sout_o | output | STAGES*W | A shift-out of every stage; the top slice continues the chain |
| b_sout_o | output | STAGES*W | B shift-out of every stage; the top slice continues the chain |
| prod_o | output | STAGES*2*W | Signed product of each stage |

## Verification
Two events can land in the same cycle: a clear and a load request on the same register, and a sample shift on the A line alongside a parallel coefficient load on the B line. The bench raises a register's selected clear together with its selected enable and new data, and requires the register to stay at zero. It then runs a FIR pass in which the A line steps and the B line takes its coefficients on the very same edge. Each step is judged against a filter sum that the bench works out from its own sample history.

// File: rtl/opchain_pkg.sv
package opchain_pkg;
  localparam int NCTL = 4;
  localparam int SELW = $clog2(NCTL);

  typedef struct packed {
    logic            bypass;
    logic            shift;
    logic [SELW-1:0] ena_sel;
    logic [SELW-1:0] clr_sel;
  } opcfg_t;
endpackage

// File: rtl/opchain_reg.sv
module opchain_reg
  import opchain_pkg::*;
#(
  parameter int W = 18
) (
  input  logic            clk,
  input  logic [NCTL-1:0] ena_pool,
  input  logic [NCTL-1:0] clr_pool,
  input  opcfg_t          cfg,
  input  logic [W-1:0]    par_d,
  input  logic [W-1:0]    shift_d,
  output logic [W-1:0]    q_o
);
  logic [W-1:0] d_sel;
  logic [W-1:0] q_reg;
  logic         load_fire;
  logic         clr_hit;

  assign d_sel     = cfg.shift ? shift_d : par_d;
  assign load_fire = ena_pool[cfg.ena_sel];
  assign clr_hit   = clr_pool[cfg.clr_sel];

  always_ff @(posedge clk or posedge clr_hit) begin
    if (clr_hit)        q_reg <= '0;
    else if (load_fire) q_reg <= d_sel;
  end

  assign q_o = cfg.bypass ? d_sel : q_reg;

  // R3: while the chosen clear is high the register reads zero
  assert_clear_zero_R3: assert property (@(posedge clk)
    clr_hit |-> q_reg == '0);

  // R4: no load request means the value is kept
  assert_hold_R4: assert property (@(posedge clk) disable iff (clr_hit)
    !load_fire |=> q_reg == $past(q_reg));

  // R1/R2: a load request captures the selected source
  assert_load_R1: assert property (@(posedge clk) disable iff (clr_hit)
    load_fire |=> q_reg == $past(d_sel));
endmodule

// File: rtl/opchain_stage.sv
module opchain_stage
  import opchain_pkg::*;
#(
  parameter int W  = 18,
  parameter int NW = 9
) (
  input  logic            clk,
  input  logic [NCTL-1:0] ena_pool,
  input  logic [NCTL-1:0] clr_pool,
  input  logic            wide,
  input  opcfg_t          a_cfg,
  input  opcfg_t          b_cfg,
  input  logic [W-1:0]    a_par,
  input  logic [W-1:0]    b_par,
  input  logic [W-1:0]    a_chain,
  input  logic [W-1:0]    b_chain,
  output logic [W-1:0]    a_q,
  output logic [W-1:0]    b_q,
  output logic [2*W-1:0]  prod
);
  localparam int PW = 2 * W;
  localparam int NP = 2 * NW;

  function automatic logic signed [W-1:0] narrow_op(logic [W-1:0] v, logic full);
    if (full) return signed'(v);
    return signed'({{(W-NW){v[NW-1]}}, v[NW-1:0]});
  endfunction

  function automatic logic [PW-1:0] op_product(logic [W-1:0] a, logic [W-1:0] b,
                                              logic full);
    logic signed [PW-1:0] p;
    p = narrow_op(a, full) * narrow_op(b, full);
    return p;
  endfunction

  opchain_reg #(.W(W)) u_areg (
    .clk(clk), .ena_pool(ena_pool), .clr_pool(clr_pool), .cfg(a_cfg),
    .par_d(a_par), .shift_d(a_chain), .q_o(a_q));

  opchain_reg #(.W(W)) u_breg (
    .clk(clk), .ena_pool(ena_pool), .clr_pool(clr_pool), .cfg(b_cfg),
    .par_d(b_par), .shift_d(b_chain), .q_o(b_q));

  assign prod = op_product(a_q, b_q, wide);

  // R7: in narrow mode the upper product bits are pure sign extension
  assert_narrow_ext_R7: assert property (@(posedge clk) disable iff (clr_pool != '0)
    !wide |-> (prod[PW-1:NP-1] == '0) || (&prod[PW-1:NP-1]));
endmodule

// File: rtl/opreg_shift_chain.sv
module opreg_shift_chain
  import opchain_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int W      = 18,
  parameter int NW     = 9
) (
  input  logic                    clk,
  input  logic [NCTL-1:0]         ena_i,
  input  logic [NCTL-1:0]         aclr_i,
  input  logic [STAGES-1:0]       wide_i,
  input  logic [STAGES-1:0]       a_bypass_i,
  input  logic [STAGES-1:0]       a_shift_i,
  input  logic [SELW*STAGES-1:0]  a_ena_sel_i,
  input  logic [SELW*STAGES-1:0]  a_clr_sel_i,
  input  logic [STAGES-1:0]       b_bypass_i,
  input  logic [STAGES-1:0]       b_shift_i,
  input  logic [SELW*STAGES-1:0]  b_ena_sel_i,
  input  logic [SELW*STAGES-1:0]  b_clr_sel_i,
  input  logic [STAGES*W-1:0]     a_data_i,
  input  logic [STAGES*W-1:0]     b_data_i,
  input  logic [W-1:0]            a_sin_i,
  input  logic [W-1:0]            b_sin_i,
  output logic [STAGES*W-1:0]     a_sout_o,
  output logic [STAGES*W-1:0]     b_sout_o,
  output logic [STAGES*2*W-1:0]   prod_o
);
  localparam int PW = 2 * W;

  logic [W-1:0] a_q [STAGES];
  logic [W-1:0] b_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    opcfg_t       a_cfg, b_cfg;
    logic [W-1:0] a_in, b_in;

    assign a_cfg = '{bypass: a_bypass_i[i], shift: a_shift_i[i],
                     ena_sel: a_ena_sel_i[SELW*i +: SELW],
                     clr_sel: a_clr_sel_i[SELW*i +: SELW]};
    assign b_cfg = '{bypass: b_bypass_i[i], shift: b_shift_i[i],
                     ena_sel: b_ena_sel_i[SELW*i +: SELW],
                     clr_sel: b_clr_sel_i[SELW*i +: SELW]};

    if (i == 0) begin : g_head
      assign a_in = a_sin_i;
      assign b_in = b_sin_i;
    end else begin : g_link
      assign a_in = a_q[i-1];
      assign b_in = b_q[i-1];
    end

    opchain_stage #(.W(W), .NW(NW)) u_stage (
      .clk(clk), .ena_pool(ena_i), .clr_pool(aclr_i), .wide(wide_i[i]),
      .a_cfg(a_cfg), .b_cfg(b_cfg),
      .a_par(a_data_i[W*i +: W]), .b_par(b_data_i[W*i +: W]),
      .a_chain(a_in), .b_chain(b_in),
      .a_q(a_q[i]), .b_q(b_q[i]),
      .prod(prod_o[PW*i +: PW]));

    assign a_sout_o[W*i +: W] = a_q[i];
    assign b_sout_o[W*i +: W] = b_q[i];
  end
endmodule

// File: tb/opreg_shift_chain_test.sv
`timescale 1ns/1ps
module opreg_shift_chain_test;
  localparam int N = 4;
  localparam int W = 18;

  logic            clk = 1'b0;
  logic [3:0]      ena_i, aclr_i;
  logic [N-1:0]    wide_i, a_bypass_i, a_shift_i, b_bypass_i, b_shift_i;
  logic [2*N-1:0]  a_ena_sel_i, a_clr_sel_i, b_ena_sel_i, b_clr_sel_i;
  logic [N*W-1:0]  a_data_i, b_data_i, a_sout_o, b_sout_o;
  logic [W-1:0]    a_sin_i, b_sin_i;
  logic [N*2*W-1:0] prod_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5679;

  opreg_shift_chain #(.STAGES(N), .W(W)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rnd(output logic [W-1:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed[W-1:0];
  endtask

  function automatic longint s18(logic [W-1:0] v);
    logic signed [W-1:0] t = v;
    return longint'(t);
  endfunction

  function automatic longint s9(logic [W-1:0] v);
    logic signed [8:0] t = v[8:0];
    return longint'(t);
  endfunction

  function automatic logic [W-1:0] asl(int i);
    return a_sout_o[W*i +: W];
  endfunction
  function automatic logic [W-1:0] bsl(int i);
    return b_sout_o[W*i +: W];
  endfunction
  function automatic longint pr(int i);
    logic signed [2*W-1:0] t = prod_o[2*W*i +: 2*W];
    return longint'(t);
  endfunction
  function automatic longint prod_sum();
    longint s = 0;
    for (int i = 0; i < N; i++) s += pr(i);
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] av [N];
    logic [W-1:0] bv [N];
    logic [W-1:0] sv [N];
    logic [W-1:0] coef [N];
    logic [W-1:0] hist [N];
    logic [W-1:0] t;
    longint ref_y;

    // pool: A uses enable/clear 0, B uses enable/clear 1
    aclr_i = 4'hF; ena_i = 4'h0;
    wide_i = '1; a_bypass_i = '0; b_bypass_i = '0;
    a_shift_i = '0; b_shift_i = '0;
    a_ena_sel_i = 8'h00; a_clr_sel_i = 8'h00;
    b_ena_sel_i = 8'h55; b_clr_sel_i = 8'h55;
    a_data_i = '0; b_data_i = '0; a_sin_i = '0; b_sin_i = '0;
    #1;
    for (int i = 0; i < N; i++) begin
      chk("R3", "reset A", longint'(asl(i)), 0);
      chk("R3", "reset B", longint'(bsl(i)), 0);
    end
    tick();
    aclr_i = 4'h0;

    // R1 / R6: parallel loads, full-width products incl. extremes
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < N; i++) begin
        rnd(av[i]); rnd(bv[i]);
        if (k == 0) begin av[i] = 18'h20000; bv[i] = 18'h20000; end
        if (k == 1) begin av[i] = 18'h1FFFF; bv[i] = 18'h20000; end
        a_data_i[W*i +: W] = av[i]; b_data_i[W*i +: W] = bv[i];
      end
      ena_i = 4'h3;
      tick();
      for (int i = 0; i < N; i++) begin
        chk("R1", "parallel A", longint'(asl(i)), longint'(av[i]));
        chk("R1", "parallel B", longint'(bsl(i)), longint'(bv[i]));
        chk("R6", "wide product", pr(i), s18(av[i]) * s18(bv[i]));
      end
    end

    // R4: unselected enables do not load
    for (int i = 0; i < N; i++) begin
      rnd(t); a_data_i[W*i +: W] = t; rnd(t); b_data_i[W*i +: W] = t;
    end
    ena_i = 4'hC;
    tick(); tick();
    for (int i = 0; i < N; i++) begin
      chk("R4", "hold A", longint'(asl(i)), longint'(av[i]));
      chk("R4", "hold B", longint'(bsl(i)), longint'(bv[i]));
    end

    // R3: unselected clears have no effect
    aclr_i = 4'hC;
    #1;
    for (int i = 0; i < N; i++)
      chk("R3", "unselected clear", longint'(asl(i)), longint'(av[i]));
    // R3: A clear is independent of B, asynchronous
    aclr_i = 4'h1;
    #1;
    for (int i = 0; i < N; i++) begin
      chk("R3", "A cleared", longint'(asl(i)), 0);
      chk("R3", "B untouched", longint'(bsl(i)), longint'(bv[i]));
    end
    // R3: clear wins over a concurrent enable
    ena_i = 4'h1;
    tick();
    for (int i = 0; i < N; i++)
      chk("R3", "clear beats load", longint'(asl(i)), 0);
    aclr_i = 4'h0;
    ena_i = 4'h0;

    // R2: A delay line, B frozen
    a_shift_i = '1;
    for (int i = 0; i < N; i++) sv[i] = '0;
    ena_i = 4'h1;
    for (int k = 0; k < 8; k++) begin
      rnd(t);
      a_sin_i = t;
      tick();
      for (int i = N - 1; i > 0; i--) sv[i] = sv[i-1];
      sv[0] = t;
      for (int i = 0; i < N; i++)
        chk("R2", "A delay line", longint'(asl(i)), longint'(sv[i]));
    end
    for (int i = 0; i < N; i++)
      chk("R4", "B frozen during A shift", longint'(bsl(i)), longint'(bv[i]));

    // R8: stage 2 in parallel mode ends the chain above it
    a_shift_i = 4'b1011;
    a_data_i[W*2 +: W] = 18'h0ABCD;
    for (int k = 0; k < 3; k++) begin
      rnd(t);
      a_sin_i = t;
      tick();
      sv[3] = sv[2]; sv[2] = 18'h0ABCD; sv[1] = sv[0]; sv[0] = t;
      for (int i = 0; i < N; i++)
        chk("R8", "chain break", longint'(asl(i)), longint'(sv[i]));
    end

    // R5: bypass stage 1 passes stage 0 through with no delay
    a_shift_i = '1;
    a_bypass_i = 4'b0010;
    #1;
    chk("R5", "bypass shift-out", longint'(asl(1)), longint'(sv[0]));
    chk("R5", "bypass product", pr(1), s18(sv[0]) * s18(bv[1]));
    rnd(t);
    a_sin_i = t;
    tick();
    chk("R5", "bypass feeds next", longint'(asl(2)), longint'(sv[0]));
    chk("R5", "bypass follows stage0", longint'(asl(1)), longint'(t));
    a_bypass_i = '0;
    ena_i = 4'h0;

    // R7: narrow mode uses signed bits [8:0]; full value still shifts
    wide_i = '0;
    a_shift_i = '0;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < N; i++) begin
        rnd(av[i]); rnd(bv[i]);
        if (k == 0) begin av[i] = 18'h3F100; bv[i] = 18'h00100; end
        a_data_i[W*i +: W] = av[i]; b_data_i[W*i +: W] = bv[i];
      end
      ena_i = 4'h3;
      tick();
      for (int i = 0; i < N; i++) begin
        chk("R7", "narrow product", pr(i), s9(av[i]) * s9(bv[i]));
        chk("R7", "full value kept", longint'(asl(i)), longint'(av[i]));
      end
    end
    wide_i = '1;

    // R9 serial: coefficients shifted in on B, A frozen
    b_shift_i = '1;
    for (int i = 0; i < N; i++) rnd(coef[i]);
    ena_i = 4'h2;
    for (int k = N - 1; k >= 0; k--) begin
      b_sin_i = coef[k];
      tick();
    end
    for (int i = 0; i < N; i++)
      chk("R2", "B serial coefficient", longint'(bsl(i)), longint'(coef[i]));
    a_shift_i = '1;
    for (int i = 0; i < N; i++) hist[i] = asl(i);
    ena_i = 4'h1;
    for (int n = 0; n < 20; n++) begin
      rnd(t);
      a_sin_i = t;
      tick();
      for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = t;
      ref_y = 0;
      for (int i = 0; i < N; i++) ref_y += s18(coef[i]) * s18(hist[i]);
      chk("R9", "FIR serial coeffs", prod_sum(), ref_y);
    end

    // R9 parallel: coefficients loaded on the same edge as a sample shift
    b_shift_i = '0;
    for (int i = 0; i < N; i++) begin
      rnd(coef[i]);
      b_data_i[W*i +: W] = coef[i];
    end
    ena_i = 4'h3;
    for (int n = 0; n < 20; n++) begin
      rnd(t);
      a_sin_i = t;
      tick();
      ena_i = 4'h1;
      for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = t;
      ref_y = 0;
      for (int i = 0; i < N; i++) ref_y += s18(coef[i]) * s18(hist[i]);
      chk("R9", "FIR parallel coeffs", prod_sum(), ref_y);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule